// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block holds the pending interrupt causes of a device and turns them into interrupt lines. It has two 32-bit cause registers. The multi-vector cause register is split into equal groups of bits, one group per interrupt vector. The legacy cause register drives a single line. A one-cycle pulse on an event input sets the matching cause bit. The bit then stays set until the host clears it. Each cause register has its own mask register of the same width. A cause bit raises an interrupt only while its mask bit is 1.

The host reaches the bank through a simple register bus with an address, a write strobe, a read strobe and combinational read data. There are three ways to clear the multi-vector causes, chosen by the software flow in use:
- Writing ones clears exactly those bits.
- Reading the register returns its value and empties it.
- With the mode bit on, the bank clears the enabled causes of a vector by itself, one cycle after that vector's line was high.

The legacy cause register can only be cleared by reading it. In every clearing path, an event arriving in the same cycle as the clear wins, so no event is lost.

Top module: `irq_cause_bank`

## Requirements
- R1: After a synchronous active-low reset, both cause registers, both masks and the mode bit are 0, and every interrupt output is low.
- R2: A 1 on `ext_evt[i]` or `leg_evt[i]` at a clock edge sets the matching cause bit at that edge. The bit stays 1 until a clearing action removes it.
- R3: A write to address 0 clears each multi-vector cause bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A read with `bus_addr` 0 (multi-vector cause) or 2 (legacy cause) shows the current contents on `bus_rdata` in that cycle, and clears the whole register at the closing edge. Each cycle of `bus_rd` counts as one read.
- R5: When an event sets a bit in the same cycle that a write, a read or an auto-clear would clear it, the bit ends up 1.
- R6: A write to address 2 does not change the legacy cause register.
- R7: `vec_irq[v]` is the OR of (cause AND mask) over multi-vector bits v*8 to v*8+7 (4 vectors at the default size). `leg_irq` is the OR of legacy cause AND legacy mask. `any_irq` is the OR of all vector lines and `leg_irq`.
- R8: Bit 0 of the mode register at address 4 enables auto-clear. While it is 1, every edge at which `vec_irq[v]` is high clears the enabled (masked-in) cause bits of group v. Masked-out bits and other groups are untouched. While it is 0, nothing is cleared automatically.
- R9: The multi-vector mask (address 1), the legacy mask (address 3) and the mode register (address 4, bit 0, other bits read 0) read back what was written. Addresses 5 to 7 read 0, and writes to them change nothing.
- R10: `bus_rdata` is 0 in every cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| ext_evt | input | 32 | Event pulses that set multi-vector cause bits |
| leg_evt | input | 32 | Event pulses that set legacy cause bits |
| vec_irq | output | 4 | Per-vector interrupt lines |
| leg_irq | output | 1 | Legacy interrupt line |
| any_irq | output | 1 | Summary of all interrupt lines |

## Verification
The bench drives events into the same cycle as a write-one-to-clear, a read-clear and an auto-clear of the same bits:
- A design that lets the clear win would drop those events.
- A design that applies the set only a cycle late would show a missing bit on the read that follows.

The bench writes all ones to the legacy cause address, to catch a bank that treats that register like the multi-vector one. It also runs auto-clear with a mix of masked-in and masked-out bits:
- Clearing the whole group would wrongly remove the masked-out bits.
- Clearing the wrong group would leave a line stuck high.
- Keeping the auto-clear on after the mode is switched off would remove causes nobody cleared.

A long run of random traffic with mixed read and write strobes then exposes any wrong address decoding, and any read data that leaks when there is no read.

// File: rtl/irq_cause_pkg.sv
// Shared constants of the interrupt cause bank: the register address map
// and the position of the auto-clear enable in the mode register.
package irq_cause_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_EXT_CAUSE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_EXT_MASK  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_LEG_CAUSE = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LEG_MASK  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MODE      = 3'd4;

    localparam int MODE_AUTOCLR_BIT = 0;
endpackage

// File: rtl/irq_cause_reg.sv
// Cause register: a bank of sticky bits.
// Assumes: set_i carries one-cycle event pulses; clr_i is the union of all
// clear requests for this cycle. A set in the same cycle as a clear wins.
module irq_cause_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o
);
    logic [W-1:0] cause_q;

    // Update every bit: the set term is ORed after the clear, so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= set_i | (cause_q & ~clr_i);
        end
    end

    assign cause_o = cause_q;

    // R2 R5
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cause_q & $past(set_i)) == $past(set_i)));

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cause_q & $past(clr_i & ~set_i)) == '0));

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cause_q & ~$past(set_i | clr_i)) ==
                          ($past(cause_q) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/irq_regif.sv
// Host register interface: decodes the bus and holds the two masks and the
// mode bit. It turns writes and reads into clear requests and muxes the
// read data.
// Assumes: bus_wr and bus_rd are one-cycle strobes and the read data is
// taken in the strobe cycle.
module irq_regif
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      ext_cause,
    input  logic [W-1:0]      leg_cause,
    output logic [W-1:0]      ext_mask,
    output logic [W-1:0]      leg_mask,
    output logic              autoclr,
    output logic [W-1:0]      ext_clr,
    output logic [W-1:0]      leg_clr
);
    logic [W-1:0] ext_mask_q;
    logic [W-1:0] leg_mask_q;
    logic         autoclr_q;
    logic         hit_ext_cause;
    logic         hit_leg_cause;

    assign hit_ext_cause = (bus_addr == ADR_EXT_CAUSE);
    assign hit_leg_cause = (bus_addr == ADR_LEG_CAUSE);

    // Holds the mask and mode registers; unmapped writes fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_mask_q <= '0;
            leg_mask_q <= '0;
            autoclr_q  <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_EXT_MASK: ext_mask_q <= bus_wdata;
                ADR_LEG_MASK: leg_mask_q <= bus_wdata;
                ADR_MODE:     autoclr_q  <= bus_wdata[MODE_AUTOCLR_BIT];
                default:      ;
            endcase
        end
    end

    // Clear requests: write-one-to-clear on the multi-vector cause only,
    // clear-on-read on both cause registers.
    always_comb begin
        ext_clr = '0;
        leg_clr = '0;
        if (bus_wr && hit_ext_cause) ext_clr = ext_clr | bus_wdata;
        if (bus_rd && hit_ext_cause) ext_clr = '1;
        if (bus_rd && hit_leg_cause) leg_clr = '1;
    end

    // Read mux, forced to zero outside a read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADR_EXT_CAUSE: bus_rdata = ext_cause;
                ADR_EXT_MASK:  bus_rdata = ext_mask_q;
                ADR_LEG_CAUSE: bus_rdata = leg_cause;
                ADR_LEG_MASK:  bus_rdata = leg_mask_q;
                ADR_MODE:      bus_rdata = {{(W-1){1'b0}}, autoclr_q};
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign ext_mask = ext_mask_q;
    assign leg_mask = leg_mask_q;
    assign autoclr  = autoclr_q;

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R9
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_EXT_MASK) |=> (ext_mask_q == $past(bus_wdata)));
endmodule

// File: rtl/irq_vec_map.sv
// Vector mapping: combines each cause with its mask, ORs the enabled bits
// of each vector group into a line, and builds the auto-clear request.
// Assumes: W is a multiple of NVEC; group v owns bits v*GRP .. v*GRP+GRP-1.
module irq_vec_map #(
    parameter int W    = 32,
    parameter int NVEC = 4
) (
    input  logic [W-1:0]    ext_cause,
    input  logic [W-1:0]    ext_mask,
    input  logic [W-1:0]    leg_cause,
    input  logic [W-1:0]    leg_mask,
    input  logic            autoclr,
    output logic [NVEC-1:0] vec_irq,
    output logic            leg_irq,
    output logic            any_irq,
    output logic [W-1:0]    acl_clr
);
    localparam int GRP = W / NVEC;

    logic [W-1:0] ext_en;

    assign ext_en = ext_cause & ext_mask;

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        // One line per group; auto-clear targets only enabled bits.
        assign vec_irq[v]             = |ext_en[v*GRP +: GRP];
        assign acl_clr[v*GRP +: GRP]  = (autoclr && vec_irq[v]) ?
                                        ext_en[v*GRP +: GRP] : '0;
    end

    assign leg_irq = |(leg_cause & leg_mask);
    assign any_irq = (|vec_irq) | leg_irq;
endmodule

// File: rtl/irq_cause_bank.sv
// Interrupt cause bank top: two cause registers, the host register
// interface and the vector mapping. The multi-vector register takes clears
// from writes, reads and auto-clear. The legacy one takes clears from
// reads only.
// Assumes: events are one-cycle pulses and reset is synchronous, active low.
module irq_cause_bank
    import irq_cause_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NVEC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  ext_evt,
    input  logic [WIDTH-1:0]  leg_evt,
    output logic [NVEC-1:0]   vec_irq,
    output logic              leg_irq,
    output logic              any_irq
);
    localparam int GRP = WIDTH / NVEC;

    logic [WIDTH-1:0] ext_cause;
    logic [WIDTH-1:0] leg_cause;
    logic [WIDTH-1:0] ext_mask;
    logic [WIDTH-1:0] leg_mask;
    logic             autoclr;
    logic [WIDTH-1:0] bus_ext_clr;
    logic [WIDTH-1:0] bus_leg_clr;
    logic [WIDTH-1:0] acl_clr;
    logic [WIDTH-1:0] ext_clr_all;

    assign ext_clr_all = bus_ext_clr | acl_clr;

    irq_cause_reg #(.W(WIDTH)) i_ext_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ext_evt),
        .clr_i   (ext_clr_all),
        .cause_o (ext_cause)
    );

    irq_cause_reg #(.W(WIDTH)) i_leg_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (leg_evt),
        .clr_i   (bus_leg_clr),
        .cause_o (leg_cause)
    );

    irq_regif #(.W(WIDTH)) i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ext_cause (ext_cause),
        .leg_cause (leg_cause),
        .ext_mask  (ext_mask),
        .leg_mask  (leg_mask),
        .autoclr   (autoclr),
        .ext_clr   (bus_ext_clr),
        .leg_clr   (bus_leg_clr)
    );

    irq_vec_map #(.W(WIDTH), .NVEC(NVEC)) i_vec_map (
        .ext_cause (ext_cause),
        .ext_mask  (ext_mask),
        .leg_cause (leg_cause),
        .leg_mask  (leg_mask),
        .autoclr   (autoclr),
        .vec_irq   (vec_irq),
        .leg_irq   (leg_irq),
        .any_irq   (any_irq),
        .acl_clr   (acl_clr)
    );

    // R4
    leg_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_LEG_CAUSE && leg_evt == '0) |=> (leg_cause == '0));

    // R6
    leg_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == ADR_LEG_CAUSE) |=>
        ((leg_cause & ~$past(leg_evt)) == ($past(leg_cause) & ~$past(leg_evt))));

    for (genvar v = 0; v < NVEC; v++) begin : g_acl_chk
        // R8
        acl_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (autoclr && vec_irq[v] && ext_evt[v*GRP +: GRP] == '0) |=>
            ((ext_cause[v*GRP +: GRP] & $past(ext_mask[v*GRP +: GRP])) == '0));
    end

    // R7
    any_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq == ((|vec_irq) || leg_irq));
endmodule

// File: tb/test_irq_cause_bank.sv
module test_irq_cause_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_evt = '0;
    logic [31:0] leg_evt = '0;
    logic [3:0]  vec_irq;
    logic        leg_irq;
    logic        any_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    // Reference model state
    logic [31:0] m_ext = '0, m_leg = '0, m_emask = '0, m_lmask = '0;
    bit          m_ac = 1'b0;

    always #10 clk = ~clk;

    irq_cause_bank i_irq_cause_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_evt(ext_evt), .leg_evt(leg_evt), .vec_irq(vec_irq),
        .leg_irq(leg_irq), .any_irq(any_irq)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_fail++;
            $display("FAIL R1 watchdog act=%0d exp=<100000 cycles", cyc_cnt);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare against the model, advance the model.
    task automatic cyc(string req, logic [2:0] a, logic w, logic r,
                       logic [31:0] wd, logic [31:0] ee, logic [31:0] le);
        logic [3:0]  e_vec;
        logic        e_leg;
        logic [31:0] e_rd;
        logic [31:0] n_ext;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = wd;
        ext_evt = ee; leg_evt = le;
        #1;
        e_vec = '0;
        for (int v = 0; v < 4; v++)
            for (int b = 0; b < 8; b++)
                if (m_ext[v*8+b] && m_emask[v*8+b]) e_vec[v] = 1'b1;
        e_leg = ((m_leg & m_lmask) != 0);
        e_rd = '0;
        if (r) begin
            case (a)
                3'd0: e_rd = m_ext;
                3'd1: e_rd = m_emask;
                3'd2: e_rd = m_leg;
                3'd3: e_rd = m_lmask;
                3'd4: e_rd = {31'b0, m_ac};
                default: e_rd = '0;
            endcase
        end
        chk(req, "vec_irq", {28'b0, vec_irq}, {28'b0, e_vec});
        chk(req, "leg_irq", {31'b0, leg_irq}, {31'b0, e_leg});
        chk(req, "any_irq", {31'b0, any_irq}, {31'b0, (e_vec != 0) || e_leg});
        chk(req, "bus_rdata", bus_rdata, e_rd);
        // next state
        for (int b = 0; b < 32; b++) begin
            bit clr;
            clr = (w && a == 3'd0 && wd[b]) || (r && a == 3'd0) ||
                  (m_ac && e_vec[b/8] && m_emask[b]);
            n_ext[b] = ee[b] ? 1'b1 : (clr ? 1'b0 : m_ext[b]);
            if (le[b]) m_leg[b] = 1'b1;
            else if (r && a == 3'd2) m_leg[b] = 1'b0;
        end
        m_ext = n_ext;
        if (w && a == 3'd1) m_emask = wd;
        if (w && a == 3'd3) m_lmask = wd;
        if (w && a == 3'd4) m_ac = wd[0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 5; a++) cyc("R1", 3'(a), 0, 1, 0, 0, 0);
        // R9: masks and mode read back
        cyc("R9", 3'd1, 1, 0, 32'h0000_FF0F, 0, 0);
        cyc("R9", 3'd3, 1, 0, 32'h0000_0003, 0, 0);
        cyc("R9", 3'd1, 0, 1, 0, 0, 0);
        cyc("R9", 3'd3, 0, 1, 0, 0, 0);
        cyc("R9", 3'd4, 1, 0, 32'hFFFF_FFFE, 0, 0);
        cyc("R9", 3'd4, 0, 1, 0, 0, 0);
        // R2 R7: events set bits, lines follow mask
        cyc("R2", 3'd0, 0, 0, 0, 32'h0001_0101, 0);
        cyc("R7", 3'd0, 0, 0, 0, 0, 0);
        cyc("R2", 3'd0, 0, 0, 0, 0, 0);
        // R3: write-one-to-clear, zeros keep
        cyc("R3", 3'd0, 1, 0, 32'h0000_0001, 0, 0);
        cyc("R3", 3'd0, 0, 0, 0, 0, 0);
        // R4: read returns and clears once
        cyc("R4", 3'd0, 0, 1, 0, 0, 0);
        cyc("R4", 3'd0, 0, 1, 0, 0, 0);
        // R5: set beats write clear and read clear
        cyc("R5", 3'd0, 0, 0, 0, 32'h0000_0004, 0);
        cyc("R5", 3'd0, 1, 0, 32'h0000_0004, 32'h0000_0004, 0);
        cyc("R5", 3'd0, 0, 1, 0, 32'h0000_0008, 0);
        cyc("R5", 3'd0, 0, 1, 0, 0, 0);
        // R6: legacy ignores writes, clears on read
        cyc("R6", 3'd2, 0, 0, 0, 0, 32'h0000_0005);
        cyc("R6", 3'd2, 1, 0, 32'hFFFF_FFFF, 0, 0);
        cyc("R6", 3'd2, 0, 1, 0, 0, 0);
        cyc("R4", 3'd2, 0, 1, 0, 0, 32'h0000_0002);
        cyc("R5", 3'd2, 0, 1, 0, 0, 0);
        // R9: unmapped addresses
        cyc("R9", 3'd6, 1, 0, 32'hFFFF_FFFF, 0, 0);
        cyc("R9", 3'd6, 0, 1, 0, 0, 0);
        cyc("R9", 3'd7, 0, 1, 0, 0, 0);
        cyc("R9", 3'd1, 0, 1, 0, 0, 0);
        // R8: auto-clear on, masked-out bits and other groups survive
        cyc("R8", 3'd4, 1, 0, 32'h1, 0, 0);
        cyc("R8", 3'd0, 0, 0, 0, 32'h00FF_00F3, 0);
        cyc("R8", 3'd0, 0, 0, 0, 32'h0000_0001, 0);
        cyc("R8", 3'd0, 0, 0, 0, 0, 0);
        cyc("R8", 3'd0, 0, 1, 0, 0, 0);
        // R8: auto-clear off keeps causes
        cyc("R8", 3'd4, 1, 0, 32'h0, 0, 0);
        cyc("R8", 3'd0, 0, 0, 0, 32'h0000_0102, 0);
        cyc("R8", 3'd0, 0, 0, 0, 0, 0);
        cyc("R8", 3'd0, 0, 1, 0, 0, 0);
        // R10 and mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [31:0] wd;
            a = 3'($urandom_range(0, 7));
            wd = (a == 3'd4) ? 32'($urandom_range(0, 1)) : $urandom;
            cyc("R10", a, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
                wd, $urandom & $urandom & $urandom, $urandom & $urandom & $urandom);
        end
        summary();
        $finish;
    end
endmodule